// File: doc/BRIEF.md
# Blocked-Multithreading Context Switch Scheduler

This block sequences the hardware contexts of a core that hides long memory latency by switching between several instruction streams. Exactly one context owns the processor at a time. It keeps the processor until a switch event arrives. Which input counts as that event depends on the selected trigger policy. After the event the context spends a fixed number of switch-cost cycles handing over the processor. It then sits out a latency countdown and becomes eligible to run again. While that happens, a round-robin picker hands the processor to the next eligible context.

Every cycle falls into exactly one of three classes: busy (a context runs), switching (a context is handing over) or idle (every context waits on memory). Three saturating counters accumulate these classes, so the block can measure efficiency directly. The switch cost and the memory latency are run-time inputs. The number of contexts is fixed at elaboration (1 to 16). The block only schedules; it does not execute instructions or model caches.

Top module: `ctx_sched`

## Requirements
- R1: During and right after reset, context 0 is running and all others are ready. `run_valid`=1, `run_id`=0 and `mode`=01 (busy), and all three counters read zero.
- R2: No more than one context is running or leaving at any time. `mode` is 01 while a context runs, 10 while a context is leaving, and 00 when neither holds (every context blocked).
- R3: A running context keeps `run_valid` high and `run_id` unchanged for as long as no trigger is sampled in its running cycles.
- R4: After a trigger the processor is in the switching mode for exactly `sw_cost` cycles, where a cost of 0 counts as 1. The cost is sampled in the trigger cycle.
- R5: After leaving, the context is blocked for exactly `mem_lat` cycles (sampled in the trigger cycle) and then becomes ready. A latency of 0 makes it ready as soon as it finishes leaving.
- R6: With `load_mode`=1, `ev_load` is the trigger. If `ev_miss` is also high in that cycle the switch carries `mem_lat` latency; otherwise its latency is zero, but the switch cost still applies.
- R7: With `load_mode`=0, `ev_miss` is the trigger and `ev_load` has no effect.
- R8: When the processor becomes free, the next context is the first eligible one in ascending ID order (wrapping modulo N), starting one past the most recently run context. The context that just left therefore has the lowest priority.
- R9: A context whose last blocked cycle, or whose zero-latency leaving phase, ends in the cycle where the processor becomes free is started at that edge, with no idle cycle in between.
- R10: `busy_cyc`, `switch_cyc` and `idle_cyc` each add one for every cycle spent in their mode, one cycle later, and hold at all-ones instead of wrapping.
- R11: `clr_cnt` zeroes all three counters at the next edge, taking priority over that cycle's increment.
- R12: A trigger seen while no context is running, whether a context is leaving or all are blocked, is ignored. It neither lengthens nor shortens any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr_cnt | input | 1 | Synchronous clear of the three cycle counters |
| load_mode | input | 1 | Trigger policy: 0 switch on miss, 1 switch on every load |
| sw_cost | input | C_W | Switch cost in cycles (0 treated as 1) |
| mem_lat | input | L_W | Latency countdown in cycles |
| ev_load | input | 1 | Running context issues a load this cycle |
| ev_miss | input | 1 | Running context takes a remote miss this cycle |
| run_valid | output | 1 | A context is running |
| run_id | output | IDW | ID of the running context |
| mode | output | 2 | Cycle class: 00 idle, 01 busy, 10 switching |
| busy_cyc | output | CNT_W | Saturating count of busy cycles |
| switch_cyc | output | CNT_W | Saturating count of switching cycles |
| idle_cyc | output | CNT_W | Saturating count of idle cycles |

## Verification
Faults in this block show up at the ports quickly. A context left in the wrong lifecycle state, or a countdown off by one, shifts the next change of `run_id` or `mode` by at least one cycle. The bench compares both outputs on every cycle, so it sees such a fault within the same handover. A wrong round-robin pointer names the wrong `run_id` at the very next pick. A missed or extra counter increment appears one cycle later in the counter value. Counter saturation is reached with a narrowed counter width.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;
    typedef enum logic [1:0] {
        CS_READY = 2'd0,
        CS_RUN   = 2'd1,
        CS_LEAVE = 2'd2,
        CS_BLOCK = 2'd3
    } ctx_st_e;

    typedef enum logic [1:0] {
        PM_IDLE   = 2'd0,
        PM_BUSY   = 2'd1,
        PM_SWITCH = 2'd2
    } pmode_e;

    localparam int NUM_MODES = 3;
endpackage

// File: rtl/ctx_slot.sv
// Lifecycle of one hardware context: READY -> RUN -> LEAVE -> BLOCK -> READY.
module ctx_slot
    import ctx_sched_pkg::*;
#(
    parameter int L_W     = 16,
    parameter bit RST_RUN = 1'b0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go_run,
    input  logic           go_leave,
    input  logic           leave_done,
    input  logic [L_W-1:0] lat_in,
    output ctx_st_e        st,
    output logic           ready_nx
);
    ctx_st_e        st_n;
    logic [L_W-1:0] cnt, cnt_n;

    // eligible for selection at the coming edge
    assign ready_nx = (st == CS_READY)
                    | ((st == CS_BLOCK) && (cnt == L_W'(1)))
                    | ((st == CS_LEAVE) && leave_done && (lat_in == '0));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RST_RUN ? CS_RUN : CS_READY;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            CS_READY: if (go_run) st_n = CS_RUN;
            CS_RUN:   if (go_leave) st_n = CS_LEAVE;
            CS_LEAVE: begin
                if (leave_done) begin
                    if (lat_in == '0) begin
                        st_n = go_run ? CS_RUN : CS_READY;
                    end else begin
                        st_n  = CS_BLOCK;
                        cnt_n = lat_in;
                    end
                end
            end
            CS_BLOCK: begin
                if (cnt == L_W'(1)) st_n = go_run ? CS_RUN : CS_READY;
                else                cnt_n = cnt - L_W'(1);
            end
            default: st_n = CS_READY;
        endcase
    end
endmodule

// File: rtl/ctx_rr_pick.sv
// Round-robin pick: first request after `last`, wrapping, `last` itself last.
module ctx_rr_pick #(
    parameter int N   = 4,
    parameter int IDW = 2
) (
    input  logic [N-1:0]   req,
    input  logic [IDW-1:0] last,
    output logic           gvalid,
    output logic [IDW-1:0] gid
);
    function automatic logic [IDW-1:0] wrap_idx(input logic [IDW-1:0] base, input int off);
        return IDW'((int'(base) + off) % N);
    endfunction

    always_comb begin
        gvalid = 1'b0;
        gid    = last;
        for (int k = 1; k <= N; k++) begin
            if (!gvalid && req[wrap_idx(last, k)]) begin
                gvalid = 1'b1;
                gid    = wrap_idx(last, k);
            end
        end
    end
endmodule

// File: rtl/ctx_perf_cnt.sv
module ctx_perf_cnt #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr)        val <= '0;
        else if (inc && ~&val)    val <= val + W'(1);
    end
endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
    import ctx_sched_pkg::*;
#(
    parameter int N_CTX  = 4,
    parameter int C_W    = 16,
    parameter int L_W    = 16,
    parameter int CNT_W  = 32,
    localparam int IDW   = (N_CTX > 1) ? $clog2(N_CTX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_cnt,
    input  logic             load_mode,
    input  logic [C_W-1:0]   sw_cost,
    input  logic [L_W-1:0]   mem_lat,
    input  logic             ev_load,
    input  logic             ev_miss,
    output logic             run_valid,
    output logic [IDW-1:0]   run_id,
    output logic [1:0]       mode,
    output logic [CNT_W-1:0] busy_cyc,
    output logic [CNT_W-1:0] switch_cyc,
    output logic [CNT_W-1:0] idle_cyc
);
    ctx_st_e          slot_st [N_CTX];
    logic [N_CTX-1:0] ready_nx, run_vec, leave_vec, act_vec, go_run, go_leave;
    logic             any_run, any_leave, trig, leave_done, free_now, gvalid;
    logic [IDW-1:0]   gid, last_id, run_id_c;
    logic [C_W-1:0]   leave_cnt;
    logic [L_W-1:0]   leave_lat;
    pmode_e           mode_c;
    logic [CNT_W-1:0] cyc [NUM_MODES];

    // ---- per-context lifecycle machines ----
    for (genvar i = 0; i < N_CTX; i++) begin : g_slot
        assign run_vec[i]   = (slot_st[i] == CS_RUN);
        assign leave_vec[i] = (slot_st[i] == CS_LEAVE);
        assign go_run[i]    = free_now && gvalid && (gid == IDW'(i));
        assign go_leave[i]  = trig && run_vec[i];

        ctx_slot #(.L_W(L_W), .RST_RUN(i == 0)) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .go_run     (go_run[i]),
            .go_leave   (go_leave[i]),
            .leave_done (leave_done),
            .lat_in     (leave_lat),
            .st         (slot_st[i]),
            .ready_nx   (ready_nx[i])
        );
    end

    assign act_vec    = run_vec | leave_vec;
    assign any_run    = |run_vec;
    assign any_leave  = |leave_vec;
    assign trig       = any_run && (load_mode ? ev_load : ev_miss);
    assign leave_done = any_leave && (leave_cnt == C_W'(1));
    assign free_now   = leave_done || ~|act_vec;

    ctx_rr_pick #(.N(N_CTX), .IDW(IDW)) u_pick (
        .req    (ready_nx),
        .last   (last_id),
        .gvalid (gvalid),
        .gid    (gid)
    );

    // ---- shared leaving-phase timer and round-robin pointer ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leave_cnt <= '0;
            leave_lat <= '0;
            last_id   <= '0;
        end else begin
            if (trig) begin
                leave_cnt <= (sw_cost == '0) ? C_W'(1) : sw_cost;
                leave_lat <= (load_mode && !ev_miss) ? '0 : mem_lat;
            end else if (any_leave) begin
                leave_cnt <= leave_cnt - C_W'(1);
            end
            if (free_now && gvalid) last_id <= gid;
        end
    end

    // ---- processor-level outputs ----
    always_comb begin
        run_id_c = '0;
        for (int i = 0; i < N_CTX; i++)
            if (run_vec[i]) run_id_c = IDW'(i);
    end

    always_comb begin
        unique case ({any_run, any_leave})
            2'b10:   mode_c = PM_BUSY;
            2'b01:   mode_c = PM_SWITCH;
            2'b00:   mode_c = PM_IDLE;
            default: mode_c = PM_IDLE;
        endcase
    end

    assign run_valid = any_run;
    assign run_id    = run_id_c;
    assign mode      = mode_c;

    for (genvar m = 0; m < NUM_MODES; m++) begin : g_cnt
        ctx_perf_cnt #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_cnt),
            .inc   (mode_c == pmode_e'(m)),
            .val   (cyc[m])
        );
    end

    assign idle_cyc   = cyc[0];
    assign busy_cyc   = cyc[1];
    assign switch_cyc = cyc[2];
endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
    parameter int N_CTX = 4,
    parameter int C_W   = 16,
    parameter int CNT_W = 32,
    parameter int IDW   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_cnt,
    input logic             trig,
    input logic [N_CTX-1:0] act_vec,
    input logic             run_valid,
    input logic [IDW-1:0]   run_id,
    input logic [1:0]       mode,
    input logic [C_W-1:0]   leave_cnt,
    input logic [CNT_W-1:0] busy_cyc,
    input logic [CNT_W-1:0] switch_cyc,
    input logic [CNT_W-1:0] idle_cyc
);
    AST_ONE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(act_vec) <= 1); // R2

    AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_valid && !trig) |=> (run_valid && run_id == $past(run_id))); // R3

    AST_TRIG_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> (mode == 2'b10)); // R4

    AST_LEAVE_UNDISTURBED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && leave_cnt > C_W'(1)) |=> (mode == 2'b10)); // R12

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_cnt && &busy_cyc) |=> (&busy_cyc)); // R10

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cnt |=> (busy_cyc == '0 && switch_cyc == '0 && idle_cyc == '0)); // R11
endmodule

bind ctx_sched ctx_sched_chk #(
    .N_CTX(N_CTX), .C_W(C_W), .CNT_W(CNT_W), .IDW(IDW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_cnt    (clr_cnt),
    .trig       (trig),
    .act_vec    (act_vec),
    .run_valid  (run_valid),
    .run_id     (run_id),
    .mode       (mode),
    .leave_cnt  (leave_cnt),
    .busy_cyc   (busy_cyc),
    .switch_cyc (switch_cyc),
    .idle_cyc   (idle_cyc)
);

// File: tb/ctx_sched_bench.sv
`timescale 1ns/1ps
module ctx_sched_bench;
    localparam int N  = 4;
    localparam int CW = 10;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr_cnt = 1'b0, load_mode = 1'b0, ev_load = 1'b0, ev_miss = 1'b0;
    logic [15:0]   sw_cost = 16'd3, mem_lat = 16'd8;
    logic          run_valid;
    logic [1:0]    run_id;
    logic [1:0]    mode;
    logic [CW-1:0] busy_cyc, switch_cyc, idle_cyc;

    always #2.5 clk = ~clk;

    ctx_sched #(.N_CTX(N), .C_W(16), .L_W(16), .CNT_W(CW)) u_ctx_sched (
        .clk(clk), .rst_n(rst_n), .clr_cnt(clr_cnt), .load_mode(load_mode),
        .sw_cost(sw_cost), .mem_lat(mem_lat), .ev_load(ev_load), .ev_miss(ev_miss),
        .run_valid(run_valid), .run_id(run_id), .mode(mode),
        .busy_cyc(busy_cyc), .switch_cyc(switch_cyc), .idle_cyc(idle_cyc)
    );

    // behavioural reference: 0 ready, 1 running, 2 leaving, 3 blocked
    int m_st [N];
    int m_wait [N];
    int m_lv, m_lvlat, m_last;
    int m_cnt [3];   // idle, busy, switching
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic int m_mode();
        for (int i = 0; i < N; i++) if (m_st[i] == 1) return 1;
        for (int i = 0; i < N; i++) if (m_st[i] == 2) return 2;
        return 0;
    endfunction

    task automatic compare(input string tag);
        int rv, rid;
        rv = 0; rid = 0;
        for (int i = 0; i < N; i++) if (m_st[i] == 1) begin rv = 1; rid = i; end
        chk(tag, "run_valid", int'(run_valid), rv);
        if (rv == 1) chk(tag, "run_id", int'(run_id), rid);
        chk(tag, "mode", int'(mode), m_mode());
        chk(tag, "idle_cyc", int'(idle_cyc), m_cnt[0]);
        chk(tag, "busy_cyc", int'(busy_cyc), m_cnt[1]);
        chk(tag, "switch_cyc", int'(switch_cyc), m_cnt[2]);
    endtask

    task automatic model_step();
        int md, nst [N];
        bit free;
        md = m_mode();
        for (int m = 0; m < 3; m++)
            if (clr_cnt) m_cnt[m] = 0;
            else if (m == md && m_cnt[m] < CMAX) m_cnt[m]++;
        free = (md == 0);
        for (int i = 0; i < N; i++) nst[i] = m_st[i];
        for (int i = 0; i < N; i++) begin
            if (m_st[i] == 2) begin
                if (m_lv == 1) begin
                    free = 1'b1;
                    if (m_lvlat == 0) nst[i] = 0;
                    else begin nst[i] = 3; m_wait[i] = m_lvlat; end
                end else m_lv--;
            end else if (m_st[i] == 3) begin
                if (m_wait[i] == 1) nst[i] = 0;
                else m_wait[i]--;
            end else if (m_st[i] == 1) begin
                if (load_mode ? ev_load : ev_miss) begin
                    nst[i] = 2;
                    m_lv = (sw_cost == 0) ? 1 : int'(sw_cost);
                    m_lvlat = (load_mode && !ev_miss) ? 0 : int'(mem_lat);
                end
            end
        end
        if (free) begin
            for (int k = 1; k <= N; k++) begin
                int idx;
                idx = (m_last + k) % N;
                if (nst[idx] == 0) begin
                    nst[idx] = 1;
                    m_last = idx;
                    break;
                end
            end
        end
        for (int i = 0; i < N; i++) m_st[i] = nst[i];
    endtask

    // one cycle: compare, drive, advance reference
    task automatic run_phase(input string tag, input int cycles, input int pmiss, input int pload,
                             input bit lm, input int cost, input int lat, input int clr_every);
        load_mode = lm;
        sw_cost   = 16'(cost);
        mem_lat   = 16'(lat);
        for (int c = 0; c < cycles; c++) begin
            compare(tag);
            ev_miss = ($urandom_range(99) < pmiss);
            ev_load = ($urandom_range(99) < pload);
            clr_cnt = (clr_every > 0) && (c % clr_every == clr_every - 1);
            model_step();
            @(negedge clk);
        end
        ev_miss = 1'b0; ev_load = 1'b0; clr_cnt = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin m_st[i] = (i == 0) ? 1 : 0; m_wait[i] = 0; end
        m_lv = 0; m_lvlat = 0; m_last = 0;
        for (int m = 0; m < 3; m++) m_cnt[m] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state seen at the ports
        chk("R1", "run_valid", int'(run_valid), 1);
        chk("R1", "run_id", int'(run_id), 0);
        chk("R1", "mode", int'(mode), 1);
        chk("R1", "busy_cyc", int'(busy_cyc), 0);
        rst_n = 1'b1;
        run_phase("R3",  30,   0,   0, 1'b0, 3,  8, 0);
        run_phase("R7",  400, 15,  40, 1'b0, 2,  6, 0);
        run_phase("R4",  300, 20,   0, 1'b0, 0,  5, 0);
        run_phase("R6",  400, 30,  50, 1'b1, 2,  9, 0);
        run_phase("R5",  400, 30,   0, 1'b0, 1, 40, 0);
        run_phase("R12", 300, 100, 100, 1'b0, 3,  3, 0);
        run_phase("R9",  300, 50,   0, 1'b0, 1,  1, 0);
        run_phase("R8",  300, 25,  25, 1'b1, 4, 12, 0);
        run_phase("R11", 200, 30,  30, 1'b0, 2,  7, 37);
        run_phase("R2",  200, 40,  40, 1'b1, 1,  3, 0);
        run_phase("R10", 2500, 0,   0, 1'b0, 2,  4, 0);
        compare("R10");
        chk("R10", "busy_cyc saturated", int'(busy_cyc), CMAX);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule